// File: doc/BRIEF.md
# Symbol-Balance Entropy Qualifier

This block decides whether one memory cell is fit to serve as a random bit source. A read engine elsewhere keeps reading the cell with a shortened activation delay. It sends each resulting bit here as one serial sample. A start pulse opens a run and tags it with a cell identifier. The block then takes a fixed number of accepted bits and cuts them into non-overlapping 3-bit symbols, with the earliest bit as the most significant. It keeps a separate occurrence count for each of the eight symbol values.

After the last bit of the run the block compares every count with an integer band around the ideal per-symbol share. It then reports a single pass or fail verdict together with the identifier. Bits left over after the last whole symbol take part in the bit count but are not counted as a symbol. A cell that only shows a balanced ones-density will still fail if some 3-bit patterns are over- or under-represented. The caller repeats a run for every operating temperature and keeps one qualified set per temperature.

Top module: `symbol_entropy_qualifier`

## Requirements
- R1: After reset, verdictValid and verdictPass are low and verdictCellId is zero.
- R2: A startPulse abandons any run in progress and clears all symbol counts. On the next cycle verdictValid and verdictPass are low and verdictCellId equals the cellIdIn value presented with the pulse. A bit offered in the same cycle as startPulse is not part of the run.
- R3: The accepted bits of a run form non-overlapping SYM_W-bit symbols, starting with the first accepted bit, with the earlier bit in the higher position. Only the first (SAMPLE_LEN / SYM_W) * SYM_W bits form symbols. The remaining tail bits do not change any count, whatever their value.
- R4: The verdict is pass exactly when each of the 2^SYM_W symbol counts lies in [LO, HI]. LO = ceil(N*(100-TOL_PCT)/(100*2^SYM_W)) and HI = floor(N*(100+TOL_PCT)/(100*2^SYM_W)), where N = SAMPLE_LEN / SYM_W. With the defaults, N = 333 and the band is 38 to 45 inclusive.
- R5: A bit is accepted only in a cycle where bitValid is high and a run is collecting. Cycles with bitValid low add nothing. Bits offered before any start, or after a run has ended, change no count and no verdict output.
- R6: The clock edge that accepts bit number SAMPLE_LEN of the run leaves verdictValid low. verdictValid rises on the following edge.
- R7: Once raised, verdictValid, verdictPass and verdictCellId hold their values until the next startPulse. verdictPass is never high while verdictValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Opens a new qualification run |
| cellIdIn | input | ID_W | Cell identifier, captured with startPulse |
| bitValid | input | 1 | bitIn carries a sample this cycle |
| bitIn | input | 1 | Sample bit read from the cell |
| verdictValid | output | 1 | A verdict for the last completed run is available |
| verdictPass | output | 1 | High when every symbol count lies in the band |
| verdictCellId | output | ID_W | Identifier of the run the verdict belongs to |

## Verification
The bench builds the block with its defaults: 1000-bit runs, 3-bit symbols and a 10% tolerance. This gives 333 symbols and a band of 38 to 45. With 333 symbols the bench can lay out streams whose counts sit exactly on 37, 38, 45 and 46. That puts both band edges, and the counts just outside them, in reach of a single run. The one leftover bit per run lets the bench show that the tail value never changes a verdict. The single-cycle gap between the last bit and the verdict lets it pin the verdict timing to one exact edge.

// File: rtl/symq_pkg.sv
package symq_pkg;

  // strobes from the sequencer to the counting datapath
  typedef struct packed {
    logic clearAll;  // new run: wipe counts, capture identifier
    logic shiftEn;   // one sample bit accepted
    logic binInc;    // accepted bit closes a full symbol
    logic judge;     // all samples in: form the verdict
  } symqCtrl_t;

endpackage

// File: rtl/symq_ctrl.sv
module symq_ctrl
  import symq_pkg::*;
#(
  parameter int SAMPLE_LEN = 1000,
  parameter int SYM_W      = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      bitValid,
  output symqCtrl_t ctrl
);

  localparam int CNT_W = $clog2(SAMPLE_LEN + 1);
  localparam int PH_W  = $clog2(SYM_W);

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_JUDGE} seqState_t;

  seqState_t        state;
  logic [CNT_W-1:0] bitCnt;
  logic [PH_W-1:0]  phase;
  logic             accept;
  logic             lastBit;
  logic             symEnd;

  assign accept  = (state == S_COLLECT) && bitValid && !startPulse;
  assign symEnd  = (phase == PH_W'(SYM_W - 1));
  assign lastBit = accept && (bitCnt == CNT_W'(SAMPLE_LEN - 1));

  always_comb begin
    ctrl          = '0;
    ctrl.clearAll = startPulse;
    ctrl.shiftEn  = accept;
    ctrl.binInc   = accept && symEnd;
    ctrl.judge    = (state == S_JUDGE) && !startPulse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      phase  <= '0;
    end else if (startPulse) begin
      state  <= S_COLLECT;
      bitCnt <= '0;
      phase  <= '0;
    end else begin
      case (state)
        S_COLLECT: begin
          if (accept) begin
            bitCnt <= bitCnt + 1'b1;
            phase  <= symEnd ? '0 : phase + 1'b1;
            if (lastBit) state <= S_JUDGE;
          end
        end
        S_JUDGE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/symq_datapath.sv
module symq_datapath
  import symq_pkg::*;
#(
  parameter int SYM_W = 3,
  parameter int BIN_W = 9,
  parameter int LO    = 38,
  parameter int HI    = 45,
  parameter int ID_W  = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  symqCtrl_t       ctrl,
  input  logic            bitIn,
  input  logic [ID_W-1:0] cellIdIn,
  output logic            verdictValid,
  output logic            verdictPass,
  output logic [ID_W-1:0] verdictCellId
);

  localparam int NUM_BINS = 1 << SYM_W;

  logic [SYM_W-2:0] shiftReg;
  logic [SYM_W-1:0] symbolNow;
  logic [NUM_BINS-1:0] inBand;

  // earlier bits occupy the higher positions
  assign symbolNow = {shiftReg, bitIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftReg <= '0;
    else if (ctrl.clearAll) shiftReg <= '0;
    else if (ctrl.shiftEn)  shiftReg <= symbolNow[SYM_W-2:0];
  end

  for (genvar g = 0; g < NUM_BINS; g++) begin : gBin
    logic [BIN_W-1:0] binCount;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                binCount <= '0;
      else if (ctrl.clearAll)   binCount <= '0;
      else if (ctrl.binInc && (symbolNow == SYM_W'(g)))
                                binCount <= binCount + 1'b1;
    end
    assign inBand[g] = (binCount >= BIN_W'(LO)) && (binCount <= BIN_W'(HI));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      verdictValid  <= 1'b0;
      verdictPass   <= 1'b0;
      verdictCellId <= '0;
    end else if (ctrl.clearAll) begin
      verdictValid  <= 1'b0;
      verdictPass   <= 1'b0;
      verdictCellId <= cellIdIn;
    end else if (ctrl.judge) begin
      verdictValid  <= 1'b1;
      verdictPass   <= &inBand;
    end
  end

endmodule

// File: rtl/symbol_entropy_qualifier.sv
module symbol_entropy_qualifier
  import symq_pkg::*;
#(
  parameter int SAMPLE_LEN = 1000,
  parameter int SYM_W      = 3,
  parameter int TOL_PCT    = 10,
  parameter int ID_W       = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startPulse,
  input  logic [ID_W-1:0] cellIdIn,
  input  logic            bitValid,
  input  logic            bitIn,
  output logic            verdictValid,
  output logic            verdictPass,
  output logic [ID_W-1:0] verdictCellId
);

  localparam int NUM_SYM  = SAMPLE_LEN / SYM_W;
  localparam int NUM_BINS = 1 << SYM_W;
  localparam int BIN_W    = $clog2(NUM_SYM + 1);
  localparam int DEN      = 100 * NUM_BINS;
  localparam int LO       = (NUM_SYM * (100 - TOL_PCT) + DEN - 1) / DEN;
  localparam int HI       = (NUM_SYM * (100 + TOL_PCT)) / DEN;

  symqCtrl_t ctrl;

  symq_ctrl #(
    .SAMPLE_LEN(SAMPLE_LEN),
    .SYM_W     (SYM_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .bitValid  (bitValid),
    .ctrl      (ctrl)
  );

  symq_datapath #(
    .SYM_W(SYM_W),
    .BIN_W(BIN_W),
    .LO   (LO),
    .HI   (HI),
    .ID_W (ID_W)
  ) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .bitIn        (bitIn),
    .cellIdIn     (cellIdIn),
    .verdictValid (verdictValid),
    .verdictPass  (verdictPass),
    .verdictCellId(verdictCellId)
  );

endmodule

// File: rtl/symq_checker.sv
module symq_checker #(
  parameter int ID_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            startPulse,
  input logic [ID_W-1:0] cellIdIn,
  input logic            bitValid,
  input logic            verdictValid,
  input logic            verdictPass,
  input logic [ID_W-1:0] verdictCellId
);

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (!verdictValid && !verdictPass && verdictCellId == $past(cellIdIn)));

  // R6
  verdict_follows_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(verdictValid) |-> $past(bitValid, 2));

  // R7
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && !startPulse) |=>
      (verdictValid && $stable(verdictPass) && $stable(verdictCellId)));

  // R7
  pass_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !verdictValid |-> !verdictPass);

  // R2
  id_only_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !startPulse |=> $stable(verdictCellId));

endmodule

bind symbol_entropy_qualifier symq_checker #(.ID_W(ID_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .startPulse   (startPulse),
  .cellIdIn     (cellIdIn),
  .bitValid     (bitValid),
  .verdictValid (verdictValid),
  .verdictPass  (verdictPass),
  .verdictCellId(verdictCellId)
);

// File: tb/sim_symbol_entropy_qualifier.sv
module sim_symbol_entropy_qualifier;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [15:0] cellIdIn = '0;
  logic        bitValid = 1'b0;
  logic        bitIn = 1'b0;
  logic        verdictValid;
  logic        verdictPass;
  logic [15:0] verdictCellId;

  int checks = 0;
  int errors = 0;
  bit stream[$];

  always #10 clk = ~clk;

  symbol_entropy_qualifier u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cellIdIn(cellIdIn),
    .bitValid(bitValid), .bitIn(bitIn), .verdictValid(verdictValid),
    .verdictPass(verdictPass), .verdictCellId(verdictCellId)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // builds 333 symbols (MSB first) from per-value counts, then one tail bit
  task automatic fillCounts(input int c[8], input bit tailBit);
    int rem[8];
    bit more;
    stream.delete();
    for (int v = 0; v < 8; v++) rem[v] = c[v];
    more = 1'b1;
    while (more) begin
      more = 1'b0;
      for (int v = 0; v < 8; v++) begin
        if (rem[v] > 0) begin
          rem[v]--;
          more = 1'b1;
          for (int b = 2; b >= 0; b--) stream.push_back(bit'((v >> b) & 1));
        end
      end
    end
    stream.push_back(tailBit);
  endtask

  task automatic runStream(input logic [15:0] id, input bit gaps, input bit startBit,
                           input bit expPass, input string req);
    @(negedge clk);
    startPulse = 1'b1; cellIdIn = id; bitValid = startBit; bitIn = 1'b1;
    @(negedge clk);
    startPulse = 1'b0; bitValid = 1'b0;
    for (int i = 0; i < stream.size(); i++) begin
      if (gaps && (i % 7 == 3)) begin
        bitValid = 1'b0; bitIn = ~stream[i];
        @(negedge clk);
      end
      bitValid = 1'b1; bitIn = stream[i];
      @(negedge clk);
    end
    bitValid = 1'b0;
    check("R6", "verdictValid on last-bit edge", verdictValid, 0);
    @(negedge clk);
    check("R6", "verdictValid one edge later", verdictValid, 1);
    check(req, "verdictPass", verdictPass, expPass);
    check("R2", "verdictCellId", verdictCellId, id);
  endtask

  task automatic testReset();
    check("R1", "verdictValid after reset", verdictValid, 0);
    check("R1", "verdictPass after reset", verdictPass, 0);
    check("R1", "verdictCellId after reset", verdictCellId, 0);
    // R5: bits with no run open are ignored
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); bitValid = 1'b1; bitIn = i[0];
    end
    @(negedge clk); bitValid = 1'b0;
    @(negedge clk);
    check("R5", "no verdict from idle bits", verdictValid, 0);
  endtask

  task automatic testUniform();
    fillCounts('{42, 42, 42, 42, 42, 41, 41, 41}, 1'b0);
    runStream(16'h0101, 1'b0, 1'b0, 1'b1, "R3");
  endtask

  task automatic testConstant();
    fillCounts('{333, 0, 0, 0, 0, 0, 0, 0}, 1'b0);
    runStream(16'h0202, 1'b0, 1'b0, 1'b0, "R4");
  endtask

  task automatic testBandEdges();
    fillCounts('{45, 41, 41, 41, 41, 41, 41, 42}, 1'b0);
    runStream(16'h0303, 1'b0, 1'b0, 1'b1, "R4");
    fillCounts('{46, 41, 41, 41, 41, 41, 41, 41}, 1'b0);
    runStream(16'h0304, 1'b0, 1'b0, 1'b0, "R4");
    fillCounts('{38, 42, 42, 42, 42, 42, 42, 43}, 1'b0);
    runStream(16'h0305, 1'b0, 1'b0, 1'b1, "R4");
    fillCounts('{37, 42, 42, 42, 42, 42, 43, 43}, 1'b0);
    runStream(16'h0306, 1'b0, 1'b0, 1'b0, "R4");
  endtask

  task automatic testTailAndGaps();
    // R3: tail bit value irrelevant; R5: idle gap cycles not counted
    fillCounts('{45, 41, 41, 41, 41, 41, 41, 42}, 1'b1);
    runStream(16'h0407, 1'b1, 1'b0, 1'b1, "R3");
    fillCounts('{42, 42, 42, 42, 42, 41, 41, 41}, 1'b1);
    runStream(16'h0408, 1'b1, 1'b0, 1'b1, "R5");
  endtask

  task automatic testHoldAfterVerdict();
    logic p;
    logic [15:0] id;
    p = verdictPass; id = verdictCellId;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); bitValid = 1'b1; bitIn = 1'b0;
    end
    @(negedge clk); bitValid = 1'b0;
    @(negedge clk);
    check("R7", "verdictValid held", verdictValid, 1);
    check("R7", "verdictPass held", verdictPass, p);
    check("R5", "verdictCellId unchanged by stray bits", verdictCellId, id);
  endtask

  task automatic testRestart();
    @(negedge clk);
    startPulse = 1'b1; cellIdIn = 16'h0AAA;
    @(negedge clk);
    startPulse = 1'b0;
    check("R2", "verdictValid cleared by start", verdictValid, 0);
    check("R2", "verdictCellId captured", verdictCellId, 16'h0AAA);
    for (int i = 0; i < 400; i++) begin
      bitValid = 1'b1; bitIn = 1'b0;
      @(negedge clk);
    end
    bitValid = 1'b0;
    fillCounts('{42, 42, 42, 42, 42, 41, 41, 41}, 1'b0);
    runStream(16'h0BBB, 1'b0, 1'b0, 1'b1, "R2");
  endtask

  task automatic testStartWithBit();
    // R2: the bit offered with the start pulse is not sampled
    fillCounts('{42, 42, 42, 42, 42, 41, 41, 41}, 1'b0);
    runStream(16'h0C0C, 1'b0, 1'b1, 1'b1, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUniform();
    testHoldAfterVerdict();
    testConstant();
    testBandEdges();
    testTailAndGaps();
    testRestart();
    testStartWithBit();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule